// File: doc/BRIEF.md
# Speculative Near-Memory Kernel Commit Checker

This controller sits at the processor-side coherence point. It decides whether a kernel that ran speculatively on a near-memory core may commit its results. While the kernel runs, the near-memory core sends no per-miss coherence traffic. The checker instead builds four compressed address signatures, each a 256-bit Bloom-style vector:

- lines the kernel read;
- lines the kernel wrote;
- lines the processor read during the same window;
- lines the processor wrote during the same window.

When the kernel-end strobe arrives, the window closes. A fixed-latency comparison of the signatures then either commits the kernel as one atomic chunk, or declares a conflict.

On a conflict, the checker asks the processor side to flush its dirty lines and waits for that flush to be acknowledged. Only then does it tell the near-memory core to roll back and re-execute. The processor is never rolled back. Aliasing in the signatures can produce a spurious conflict, but a real overlap is never missed.

The checker stays busy from kernel start until it has committed, or until the rollback has been acknowledged. A kernel start that arrives in that time is dropped.

Top module: `spec_commit_checker`

## Requirements
- R1: After reset, `busy`, `commit`, `rollback` and `flush_req` are low and all four signatures are empty.
- R2: A `kern_start` sampled while idle clears all four signatures and raises `busy` on the next cycle. Accesses presented in that same cycle are not recorded.
- R3: Recording window: it runs from the cycle after the accepted start through the cycle in which `kern_end` is sampled, inclusive. Each valid access in the window sets two bits in its own signature, at indices h0 and h1. For a 32-bit address a, h0 bit k is the XOR of all a[i] with i mod 8 == k. h1 is bits [31:24] of (a * 0x9E3779B1) mod 2^32. Accesses outside the window are dropped.
- R4: A conflict is declared when the kernel-read signature shares a set bit with the processor-write signature. It is also declared when the kernel-write signature shares a set bit with the union of the processor-read and processor-write signatures. Reads on both sides never conflict.
- R5: A decision appears exactly 4 cycles after the edge that samples `kern_end`. The decision is either a `commit` pulse or `flush_req` rising.
- R6: `commit` is a one-cycle pulse. `busy` is already low in the cycle in which `commit` is high.
- R7: `flush_req` stays high until `flush_ack` is sampled. `rollback` is then a one-cycle pulse in the next cycle, and it never rises without a preceding flush acknowledge.
- R8: After a rollback, `busy` stays high until `rb_ack` is sampled, and is low in the following cycle.
- R9: While busy, `kern_start` is ignored: the signatures are not cleared and the state does not change. This holds even when `kern_start` coincides with `rb_ack`. A `kern_end` outside the recording window is ignored.
- R10: `commit` and `rollback` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kern_start | input | 1 | Kernel start strobe |
| kern_end | input | 1 | Kernel end strobe |
| krd_vld | input | 1 | Kernel read access valid |
| krd_addr | input | 32 | Kernel read line address |
| kwr_vld | input | 1 | Kernel write access valid |
| kwr_addr | input | 32 | Kernel write line address |
| crd_vld | input | 1 | Processor read access valid |
| crd_addr | input | 32 | Processor read line address |
| cwr_vld | input | 1 | Processor write access valid |
| cwr_addr | input | 32 | Processor write line address |
| flush_ack | input | 1 | Processor dirty-line flush done |
| rb_ack | input | 1 | Near-memory core accepted the rollback |
| busy | output | 1 | A kernel is in flight or being resolved |
| commit | output | 1 | One-cycle pulse: kernel results may commit |
| flush_req | output | 1 | Request to flush processor dirty lines |
| rollback | output | 1 | One-cycle pulse: kernel must roll back and re-execute |

## Verification
The collisions that matter are the ones at the edges of the window. An access can land in the same cycle as the start strobe, where it must be dropped. It can land in the same cycle as the end strobe, where it must be kept. It can also arrive during the 4-cycle check, where it must be dropped.

A start can also coincide with the rollback acknowledge, or arrive in the middle of a running kernel. The bench drives each of these collisions directly. It judges them by the outcome the kernel later gets: if a start had wrongly cleared the signatures, a known conflict would turn into a commit. A behavioural model of signatures and states is also compared against every output on every clock. This comparison runs through directed and randomly mixed traffic, with varied acknowledge delays.

// File: rtl/pim_chk_pkg.sv
package pim_chk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_CHECK  = 3'd2,
        ST_FLUSH  = 3'd3,
        ST_RBWAIT = 3'd4
    } chk_state_e;

    localparam int unsigned NUM_SIGS = 4;
    localparam int unsigned SIG_KRD  = 0;
    localparam int unsigned SIG_KWR  = 1;
    localparam int unsigned SIG_CRD  = 2;
    localparam int unsigned SIG_CWR  = 3;

endpackage

// File: rtl/pim_sig_hash.sv
module pim_sig_hash #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned HASH_MULT = 32'h9E3779B1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx0,
    output logic [IDX_W-1:0]  idx1
);

    logic [ADDR_W-1:0] prod;

    // First index: fold the address onto IDX_W bits by XOR.
    always_comb begin
        idx0 = '0;
        for (int i = 0; i < int'(ADDR_W); i++) begin
            idx0[i % int'(IDX_W)] = idx0[i % int'(IDX_W)] ^ addr[i];
        end
    end

    // Second index: top bits of a multiplicative scramble.
    assign prod = addr * ADDR_W'(HASH_MULT);
    assign idx1 = prod[ADDR_W-1 -: IDX_W];

endmodule

// File: rtl/pim_sig_bank.sv
module pim_sig_bank #(
    parameter int unsigned SIG_BITS  = 256,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned HASH_MULT = 32'h9E3779B1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                ins,
    input  logic [ADDR_W-1:0]   addr,
    output logic [SIG_BITS-1:0] bits
);

    localparam int unsigned IDX_W = $clog2(SIG_BITS);

    logic [IDX_W-1:0]    idx0;
    logic [IDX_W-1:0]    idx1;
    logic [SIG_BITS-1:0] bits_d;
    logic [SIG_BITS-1:0] bits_q;

    pim_sig_hash #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .HASH_MULT(HASH_MULT)
    ) u_hash (
        .addr(addr),
        .idx0(idx0),
        .idx1(idx1)
    );

    // Clear wins over insertion.
    always_comb begin
        bits_d = bits_q;
        if (clr) begin
            bits_d = '0;
        end else if (ins) begin
            bits_d[idx0] = 1'b1;
            bits_d[idx1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits = bits_q;

    AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bits_q == '0)); // R2

    AST_SIG_INSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !clr) |=> (bits_q[$past(idx0)] && bits_q[$past(idx1)])); // R3

endmodule

// File: rtl/pim_sig_match.sv
module pim_sig_match #(
    parameter int unsigned SIG_BITS = 256
) (
    input  logic [SIG_BITS-1:0] k_rd,
    input  logic [SIG_BITS-1:0] k_wr,
    input  logic [SIG_BITS-1:0] c_rd,
    input  logic [SIG_BITS-1:0] c_wr,
    output logic                hit
);

    logic rd_vs_wr;
    logic wr_vs_any;

    assign rd_vs_wr  = |(k_rd & c_wr);
    assign wr_vs_any = |(k_wr & (c_rd | c_wr));
    assign hit       = rd_vs_wr | wr_vs_any;

endmodule

// File: rtl/spec_commit_checker.sv
module spec_commit_checker
    import pim_chk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SIG_BITS  = 256,
    parameter int unsigned CHECK_CYC = 4,
    parameter int unsigned HASH_MULT = 32'h9E3779B1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kern_start,
    input  logic              kern_end,
    input  logic              krd_vld,
    input  logic [ADDR_W-1:0] krd_addr,
    input  logic              kwr_vld,
    input  logic [ADDR_W-1:0] kwr_addr,
    input  logic              crd_vld,
    input  logic [ADDR_W-1:0] crd_addr,
    input  logic              cwr_vld,
    input  logic [ADDR_W-1:0] cwr_addr,
    input  logic              flush_ack,
    input  logic              rb_ack,
    output logic              busy,
    output logic              commit,
    output logic              flush_req,
    output logic              rollback
);

    localparam int unsigned CNT_W = (CHECK_CYC > 2) ? $clog2(CHECK_CYC) : 1;

    typedef struct packed {
        chk_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             conflict;
        logic             commit;
        logic             rollback;
        logic             flush;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;
    logic sig_clr;
    logic rec_en;
    logic hit;

    logic              sig_ins  [NUM_SIGS];
    logic [ADDR_W-1:0] sig_addr [NUM_SIGS];
    logic [SIG_BITS-1:0] sig_bits [NUM_SIGS];

    assign rec_en = (ctl_q.st == ST_RUN);

    assign sig_ins[SIG_KRD]  = rec_en && krd_vld;
    assign sig_ins[SIG_KWR]  = rec_en && kwr_vld;
    assign sig_ins[SIG_CRD]  = rec_en && crd_vld;
    assign sig_ins[SIG_CWR]  = rec_en && cwr_vld;
    assign sig_addr[SIG_KRD] = krd_addr;
    assign sig_addr[SIG_KWR] = kwr_addr;
    assign sig_addr[SIG_CRD] = crd_addr;
    assign sig_addr[SIG_CWR] = cwr_addr;

    for (genvar g = 0; g < NUM_SIGS; g++) begin : g_sig
        pim_sig_bank #(
            .SIG_BITS (SIG_BITS),
            .ADDR_W   (ADDR_W),
            .HASH_MULT(HASH_MULT)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (sig_clr),
            .ins  (sig_ins[g]),
            .addr (sig_addr[g]),
            .bits (sig_bits[g])
        );
    end

    pim_sig_match #(
        .SIG_BITS(SIG_BITS)
    ) u_match (
        .k_rd(sig_bits[SIG_KRD]),
        .k_wr(sig_bits[SIG_KWR]),
        .c_rd(sig_bits[SIG_CRD]),
        .c_wr(sig_bits[SIG_CWR]),
        .hit (hit)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.commit   = 1'b0;
        ctl_d.rollback = 1'b0;
        sig_clr        = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (kern_start) begin
                    sig_clr  = 1'b1;
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (kern_end) begin
                    ctl_d.st  = ST_CHECK;
                    ctl_d.cnt = '0;
                end
            end
            ST_CHECK: begin
                // Signatures are frozen here; the match result is registered.
                ctl_d.cnt      = ctl_q.cnt + 1'b1;
                ctl_d.conflict = hit;
                if (ctl_q.cnt == CNT_W'(CHECK_CYC - 1)) begin
                    if (ctl_q.conflict) begin
                        ctl_d.flush = 1'b1;
                        ctl_d.st    = ST_FLUSH;
                    end else begin
                        ctl_d.commit = 1'b1;
                        ctl_d.st     = ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                if (flush_ack) begin
                    ctl_d.flush    = 1'b0;
                    ctl_d.rollback = 1'b1;
                    ctl_d.st       = ST_RBWAIT;
                end
            end
            ST_RBWAIT: begin
                if (rb_ack) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, conflict: 1'b0,
                       commit: 1'b0, rollback: 1'b0, flush: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign commit    = ctl_q.commit;
    assign rollback  = ctl_q.rollback;
    assign flush_req = ctl_q.flush;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && rollback)); // R10

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R6

    AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy); // R6

    AST_RB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> !rollback); // R7

    AST_RB_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> $past(flush_req && flush_ack)); // R7

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req); // R7

    AST_DECIDE_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(ctl_q.st == ST_CHECK)); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CHECK && kern_start) |=> (ctl_q.st != ST_RUN)); // R9

    AST_RBWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RBWAIT && !rb_ack) |=> busy); // R8

endmodule

// File: tb/sim_spec_commit_checker.sv
module sim_spec_commit_checker;

    localparam int CHK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kern_start = 1'b0, kern_end = 1'b0;
    logic        krd_vld = 1'b0, kwr_vld = 1'b0, crd_vld = 1'b0, cwr_vld = 1'b0;
    logic [31:0] krd_addr = '0, kwr_addr = '0, crd_addr = '0, cwr_addr = '0;
    logic        flush_ack = 1'b0, rb_ack = 1'b0;
    logic        busy, commit, flush_req, rollback;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spec_commit_checker u0 (
        .clk(clk), .rst_n(rst_n), .kern_start(kern_start), .kern_end(kern_end),
        .krd_vld(krd_vld), .krd_addr(krd_addr), .kwr_vld(kwr_vld), .kwr_addr(kwr_addr),
        .crd_vld(crd_vld), .crd_addr(crd_addr), .cwr_vld(cwr_vld), .cwr_addr(cwr_addr),
        .flush_ack(flush_ack), .rb_ack(rb_ack),
        .busy(busy), .commit(commit), .flush_req(flush_req), .rollback(rollback)
    );

    function automatic logic [7:0] hsh0(logic [31:0] a);
        logic [7:0] h = '0;
        for (int i = 0; i < 32; i++) h[i % 8] = h[i % 8] ^ a[i];
        return h;
    endfunction

    function automatic logic [7:0] hsh1(logic [31:0] a);
        logic [31:0] p = a * 32'h9E3779B1;
        return p[31:24];
    endfunction

    // Behavioural reference model: 0 idle, 1 window, 2 check, 3 flush, 4 wait rb ack
    logic [255:0] m_krd, m_kwr, m_crd, m_cwr;
    int   m_st, m_cnt;
    logic m_commit, m_rb, m_flush;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_krd = '0; m_kwr = '0; m_crd = '0; m_cwr = '0;
            m_st = 0; m_cnt = 0; m_commit = 0; m_rb = 0; m_flush = 0;
        end else begin
            m_commit = 0;
            m_rb = 0;
            case (m_st)
                0: if (kern_start) begin
                    m_krd = '0; m_kwr = '0; m_crd = '0; m_cwr = '0;
                    m_st = 1;
                end
                1: begin
                    if (krd_vld) begin m_krd[hsh0(krd_addr)] = 1; m_krd[hsh1(krd_addr)] = 1; end
                    if (kwr_vld) begin m_kwr[hsh0(kwr_addr)] = 1; m_kwr[hsh1(kwr_addr)] = 1; end
                    if (crd_vld) begin m_crd[hsh0(crd_addr)] = 1; m_crd[hsh1(crd_addr)] = 1; end
                    if (cwr_vld) begin m_cwr[hsh0(cwr_addr)] = 1; m_cwr[hsh1(cwr_addr)] = 1; end
                    if (kern_end) begin m_st = 2; m_cnt = 0; end
                end
                2: begin
                    m_cnt++;
                    if (m_cnt == CHK) begin
                        if (((m_krd & m_cwr) != 0) || ((m_kwr & (m_crd | m_cwr)) != 0)) begin
                            m_flush = 1; m_st = 3;
                        end else begin
                            m_commit = 1; m_st = 0;
                        end
                    end
                end
                3: if (flush_ack) begin m_flush = 0; m_rb = 1; m_st = 4; end
                4: if (rb_ack) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 commit vs model", commit, m_commit);
            chk("R7 rollback vs model", rollback, m_rb);
            chk("R7 flush_req vs model", flush_req, m_flush);
            chk("R9 busy vs model", busy, m_st != 0);
            chk("R10 commit/rollback exclusive", commit & rollback, 1'b0);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R5 watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic clr_acc();
        krd_vld = 0; kwr_vld = 0; crd_vld = 0; cwr_vld = 0;
    endtask

    task automatic start_k();
        kern_start = 1;
        @(negedge clk);
        kern_start = 0;
    endtask

    // kind: 0 kernel read, 1 kernel write, 2 cpu read, 3 cpu write
    task automatic set_acc(int kind, logic [31:0] a);
        case (kind)
            0: begin krd_vld = 1; krd_addr = a; end
            1: begin kwr_vld = 1; kwr_addr = a; end
            2: begin crd_vld = 1; crd_addr = a; end
            default: begin cwr_vld = 1; cwr_addr = a; end
        endcase
    endtask

    task automatic acc(int kind, logic [31:0] a);
        set_acc(kind, a);
        @(negedge clk);
        clr_acc();
    endtask

    // res: 1 commit, 2 conflict; late_a != 0 injects a cpu write during the check
    task automatic end_k(output int res, output int lat, input logic [31:0] late_a);
        kern_end = 1;
        res = 0;
        lat = 0;
        while (res == 0 && lat < 20) begin
            @(negedge clk);
            kern_end = 0;
            clr_acc();
            lat++;
            if (lat == 1 && late_a != 0) set_acc(3, late_a);
            if (commit) res = 1;
            else if (flush_req) res = 2;
        end
        clr_acc();
        chk_int("R5 decision latency", lat, CHK + 1);
    endtask

    task automatic recover(int dly, bit start_on_ack);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R7 flush_req held", flush_req, 1'b1);
            chk("R7 no rollback before ack", rollback, 1'b0);
        end
        flush_ack = 1;
        @(negedge clk);
        flush_ack = 0;
        chk("R7 rollback after ack", rollback, 1'b1);
        chk("R7 flush_req dropped", flush_req, 1'b0);
        @(negedge clk);
        chk("R7 rollback one cycle", rollback, 1'b0);
        chk("R8 busy until rb ack", busy, 1'b1);
        rb_ack = 1;
        if (start_on_ack) kern_start = 1;
        @(negedge clk);
        rb_ack = 0;
        kern_start = 0;
        chk("R8 idle after rb ack", busy, 1'b0);
        if (start_on_ack) begin
            @(negedge clk);
            chk("R9 start with rb ack ignored", busy, 1'b0);
        end
    endtask

    initial begin
        int res, lat;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 commit in reset", commit, 1'b0);
        chk("R1 flush_req in reset", flush_req, 1'b0);
        chk("R1 rollback in reset", rollback, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 1'b0);

        // Fresh signatures: kernel writes alone must commit
        start_k();
        chk("R2 busy after start", busy, 1'b1);
        acc(1, 32'h0000_0100);
        end_k(res, lat, 0);
        chk_int("R1 empty signatures commit", res, 1);
        @(negedge clk);
        chk("R6 commit one cycle", commit, 1'b0);

        // Read/read sharing never conflicts
        start_k();
        acc(0, 32'h0000_0200);
        acc(2, 32'h0000_0200);
        end_k(res, lat, 0);
        chk_int("R4 read/read commits", res, 1);

        // Kernel read vs cpu write
        start_k();
        acc(0, 32'h0000_0300);
        acc(3, 32'h0000_0300);
        end_k(res, lat, 0);
        chk_int("R4 kread/cwrite conflict", res, 2);
        recover(3, 0);

        // Kernel write vs cpu read
        start_k();
        acc(1, 32'h0000_0400);
        acc(2, 32'h0000_0400);
        end_k(res, lat, 0);
        chk_int("R4 kwrite/cread conflict", res, 2);
        recover(0, 0);

        // Accesses in the start cycle are dropped
        kern_start = 1;
        set_acc(1, 32'h0000_0500);
        set_acc(3, 32'h0000_0500);
        @(negedge clk);
        kern_start = 0;
        clr_acc();
        end_k(res, lat, 0);
        chk_int("R2 start-cycle accesses dropped", res, 1);

        // Access in the kern_end cycle is recorded
        start_k();
        acc(2, 32'h0000_0600);
        set_acc(1, 32'h0000_0600);
        end_k(res, lat, 0);
        chk_int("R3 end-cycle access recorded", res, 2);
        recover(1, 0);

        // Access during the check is dropped
        start_k();
        acc(0, 32'h0000_0700);
        end_k(res, lat, 32'h0000_0700);
        chk_int("R3 access after window dropped", res, 1);

        // Start while running is ignored (no clear)
        start_k();
        acc(1, 32'h0000_0800);
        start_k();
        acc(2, 32'h0000_0800);
        end_k(res, lat, 0);
        chk_int("R9 start while busy ignored", res, 2);
        recover(2, 1);

        // End outside the window is ignored
        kern_end = 1;
        @(negedge clk);
        kern_end = 0;
        repeat (6) @(negedge clk);
        chk("R9 stray end no commit", commit, 1'b0);
        chk("R9 stray end not busy", busy, 1'b0);

        // Mixed random traffic
        for (int k = 0; k < 40; k++) begin
            start_k();
            for (int c = 0; c < 1 + int'($urandom_range(9)); c++) begin
                if ($urandom_range(3) == 0) krd_vld = 1;
                if ($urandom_range(3) == 0) kwr_vld = 1;
                if ($urandom_range(3) == 0) crd_vld = 1;
                if ($urandom_range(3) == 0) cwr_vld = 1;
                krd_addr = 32'($urandom_range(31)) << 6;
                kwr_addr = 32'($urandom_range(31)) << 6;
                crd_addr = 32'($urandom_range(31)) << 6;
                cwr_addr = 32'($urandom_range(31)) << 6;
                if ($urandom_range(7) == 0) kern_start = 1;
                @(negedge clk);
                kern_start = 0;
                clr_acc();
            end
            end_k(res, lat, 0);
            if (res == 2) recover(int'($urandom_range(3)), 1'($urandom_range(1)));
            else @(negedge clk);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule